// File: doc/BRIEF.md
# Fractional Sample-Rate Strobe Generator

This block turns one of two master audio tick streams into a sample-rate strobe. It uses an accumulator that grows on every master tick and wraps in the manner of a line-drawing error term. Each generator holds a source select and a 32-bit rate word. The rate word packs an increment together with a coded form of the modulus, so the strobe rate is the master rate times increment over modulus. With the usual increment of 4 and a modulus of 4 × master / target, one 44.1 kHz or 48 kHz base covers targets from 8 kHz to 48 kHz.

Two generators sit side by side: generator 1 for playback and generator 2 for record. Registers are loaded through a plain one-cycle write port. Each converter names the generator it wants with a clock ID and gets that generator's strobe on its own output. The master clocks come from outside as single-cycle enable ticks.

Top module: `rate_strobe_gen`

## Requirements
- R1: After reset every generator and converter strobe is low, and master ticks produce no strobe until a rate word has been written.
- R2: Source select bit 0 = 1 makes a generator count only `tick_44k1`; a value of 0 makes it count only `tick_48k`. Ticks on the other input have no effect on the output or on the count.
- R3: The rate word holds the increment in bits 15:0 and (increment − modulus − 1) modulo 2^16 in bits 31:16. The generator recovers the modulus as (bits15:0 − bits31:16 − 1) modulo 2^16.
- R4: With a usable setting, counted tick number k after a load produces a strobe exactly when floor(k·inc/mod) exceeds floor((k−1)·inc/mod). The generator strobe is one clock wide and is high in the clock after the tick.
- R5: Any write marks new settings as pending. The next tick of the newly selected source applies them, clears the accumulator to 0 and emits no strobe. While settings are pending, ticks of the other source are ignored.
- R6: A modulus of 0, or a modulus smaller than the increment, keeps the strobe low.
- R7: A converter whose clock ID is n (1 ≤ n ≤ generator count) receives generator n's strobe one clock later. An ID of 0 or an ID above the count gives a low strobe.
- R8: Write address bit 0 picks the register (0 = source select, 1 = rate word) and the upper bits pick the generator (0 = generator 1, playback; 1 = generator 2, record). A write to one generator leaves the other's count and output untouched.
- R9: Ticks on both inputs in the same cycle count as a single tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_44k1 | input | 1 | One-cycle tick of the 44.1 kHz-family master |
| tick_48k | input | 1 | One-cycle tick of the 48 kHz-family master |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | {generator index, register select} |
| wr_data | input | 32 | Write data |
| conv_id | input | 4 | Clock ID per converter, 2 bits each |
| gen_strobe | output | 2 | Strobe of each generator |
| conv_strobe | output | 2 | Strobe delivered to each converter |

## Verification
The main function is run with the settings a driver derives for the common audio rates from 8 kHz to 48 kHz, on both bases. It is also swept over a full grid of increments 1 to 5 against moduli 0 to 8, on both generators and both sources. The grid separates exact division, fractional patterns and unusable settings. Ticks on the unselected source and ticks on both inputs in one cycle are mixed into the sequence, which shows whether a stray or doubled tick moves the count. Pending-select, clock-ID routing and concurrent operation of both generators under a mid-run rewrite check that the load point and the generators' independence fall where R5 and R8 place them.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  parameter int FIELD_W = 16;
  localparam int WORD_W = 2 * FIELD_W;
  typedef logic [FIELD_W-1:0] field_t;

  function automatic field_t recover_mod(field_t inc, field_t neg);
    return inc - neg - field_t'(1);
  endfunction

  function automatic logic cfg_usable(field_t inc, field_t modv);
    return (modv != '0) && (modv >= inc);
  endfunction
endpackage

// File: rtl/rsg_cfg.sv
module rsg_cfg
  import rsg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_src,
  input  logic              wr_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              tick_44k1,
  input  logic              tick_48k,
  output logic              src_tick,
  output logic              load,
  output field_t            act_inc,
  output field_t            act_mod
);
  logic   sh_src, act_src, pend;
  field_t sh_inc, sh_neg, act_neg;
  logic   new_tick, old_tick;

  assign new_tick = sh_src  ? tick_44k1 : tick_48k;
  assign old_tick = act_src ? tick_44k1 : tick_48k;
  assign src_tick = pend ? new_tick : old_tick;
  assign load     = pend & new_tick;
  assign act_mod  = recover_mod(act_inc, act_neg);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_src  <= 1'b0;
      sh_inc  <= '0;
      sh_neg  <= '0;
      act_src <= 1'b0;
      act_inc <= '0;
      act_neg <= '0;
      pend    <= 1'b0;
    end else begin
      if (wr_src) sh_src <= wr_data[0];
      if (wr_word) begin
        sh_inc <= wr_data[FIELD_W-1:0];
        sh_neg <= wr_data[WORD_W-1:FIELD_W];
      end
      if (load) begin
        act_src <= sh_src;
        act_inc <= sh_inc;
        act_neg <= sh_neg;
      end
      if (wr_src || wr_word) pend <= 1'b1;
      else if (load)         pend <= 1'b0;
    end
  end

  // R8: the address decode never targets both registers at once
  assert_one_reg_R8: assert property (@(posedge clk) disable iff (rst)
    !(wr_src && wr_word));
endmodule

// File: rtl/rsg_accum.sv
module rsg_accum
  import rsg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   src_tick,
  input  logic   load,
  input  field_t inc,
  input  field_t modv,
  output logic   strobe
);
  field_t           acc;
  logic [FIELD_W:0] sum;
  logic             ok;

  assign ok  = cfg_usable(inc, modv);
  assign sum = {1'b0, acc} + {1'b0, inc};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      strobe <= 1'b0;
    end else if (load) begin
      acc    <= '0;
      strobe <= 1'b0;
    end else if (src_tick && ok) begin
      if (sum >= {1'b0, modv}) begin
        acc    <= field_t'(sum - {1'b0, modv});
        strobe <= 1'b1;
      end else begin
        acc    <= field_t'(sum);
        strobe <= 1'b0;
      end
    end else begin
      strobe <= 1'b0;
    end
  end

  assert_strobe_after_tick_R4: assert property (@(posedge clk) disable iff (rst)
    strobe |-> ($past(src_tick) && !$past(load)));
  assert_acc_bounded_R4: assert property (@(posedge clk) disable iff (rst)
    ok |-> (acc < modv));
  assert_no_strobe_bad_cfg_R6: assert property (@(posedge clk) disable iff (rst)
    strobe |-> $past(modv != '0 && modv >= inc));
  assert_load_clears_R5: assert property (@(posedge clk) disable iff (rst)
    $past(load) |-> (acc == '0 && !strobe));
endmodule

// File: rtl/rsg_route.sv
module rsg_route #(
  parameter int NUM_GEN  = 2,
  parameter int NUM_CONV = 2,
  parameter int ID_W     = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_GEN-1:0]       gen_strobe,
  input  logic [NUM_CONV*ID_W-1:0] conv_id,
  output logic [NUM_CONV-1:0]      conv_strobe
);
  for (genvar c = 0; c < NUM_CONV; c++) begin : g_conv
    logic [ID_W-1:0] id;
    logic            pick;
    assign id = conv_id[c*ID_W +: ID_W];

    always_comb begin
      pick = 1'b0;
      for (int j = 0; j < NUM_GEN; j++)
        if (id == ID_W'(j + 1)) pick = gen_strobe[j];
    end

    always_ff @(posedge clk) begin
      if (rst) conv_strobe[c] <= 1'b0;
      else     conv_strobe[c] <= pick;
    end

    assert_id_in_range_R7: assert property (@(posedge clk) disable iff (rst)
      conv_strobe[c] |-> $past(id != '0 && int'(id) <= NUM_GEN));
  end
endmodule

// File: rtl/rate_strobe_gen.sv
module rate_strobe_gen
  import rsg_pkg::*;
#(
  parameter int NUM_GEN  = 2,
  parameter int NUM_CONV = 2,
  localparam int GEN_W   = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1,
  localparam int ADDR_W  = GEN_W + 1,
  localparam int ID_W    = $clog2(NUM_GEN + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick_44k1,
  input  logic                     tick_48k,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [WORD_W-1:0]        wr_data,
  input  logic [NUM_CONV*ID_W-1:0] conv_id,
  output logic [NUM_GEN-1:0]       gen_strobe,
  output logic [NUM_CONV-1:0]      conv_strobe
);
  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    logic   hit, wr_src, wr_word, src_tick, load;
    field_t inc, modv;

    assign hit     = wr_en && (wr_addr[ADDR_W-1:1] == GEN_W'(g));
    assign wr_src  = hit && !wr_addr[0];
    assign wr_word = hit &&  wr_addr[0];

    rsg_cfg u_cfg (
      .clk(clk), .rst(rst), .wr_src(wr_src), .wr_word(wr_word),
      .wr_data(wr_data), .tick_44k1(tick_44k1), .tick_48k(tick_48k),
      .src_tick(src_tick), .load(load), .act_inc(inc), .act_mod(modv)
    );

    rsg_accum u_acc (
      .clk(clk), .rst(rst), .src_tick(src_tick), .load(load),
      .inc(inc), .modv(modv), .strobe(gen_strobe[g])
    );
  end

  rsg_route #(.NUM_GEN(NUM_GEN), .NUM_CONV(NUM_CONV), .ID_W(ID_W)) u_route (
    .clk(clk), .rst(rst), .gen_strobe(gen_strobe),
    .conv_id(conv_id), .conv_strobe(conv_strobe)
  );

  // R1: strobes stay low in the first cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (gen_strobe == '0 && conv_strobe == '0));
endmodule

// File: tb/sim_rate_strobe_gen.sv
module sim_rate_strobe_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_44k1 = 1'b0, tick_48k = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  cid0 = 2'd1, cid1 = 2'd2;
  logic [1:0]  gen_strobe, conv_strobe;
  int n_cmp = 0, n_bad = 0;

  // bench model, per generator
  logic   m_src [2];
  longint m_inc [2], m_neg [2], m_ainc [2], m_amod [2], m_k [2];
  logic   m_pend [2];
  logic   e_s [2];

  always #10 clk = ~clk;

  rate_strobe_gen u0 (
    .clk(clk), .rst(rst), .tick_44k1(tick_44k1), .tick_48k(tick_48k),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .conv_id({cid1, cid0}), .gen_strobe(gen_strobe), .conv_strobe(conv_strobe)
  );

  task automatic check(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic conv_exp(logic [1:0] id);
    if (id == 2'd1) return e_s[0];
    if (id == 2'd2) return e_s[1];
    return 1'b0;
  endfunction

  task automatic wr(int g, int r, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {g[0], r[0]}; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (r == 0) m_src[g] = d[0];
    else begin m_inc[g] = longint'(d[15:0]); m_neg[g] = longint'(d[31:16]); end
    m_pend[g] = 1'b1;
  endtask

  task automatic pulse(logic a, logic b, string req);
    @(negedge clk);
    tick_44k1 = a; tick_48k = b;
    @(negedge clk);
    tick_44k1 = 1'b0; tick_48k = 1'b0;
    for (int g = 0; g < 2; g++) begin
      logic h;
      h = m_src[g] ? a : b;
      e_s[g] = 1'b0;
      if (h) begin
        if (m_pend[g]) begin
          m_pend[g] = 1'b0; m_k[g] = 0;
          m_ainc[g] = m_inc[g];
          m_amod[g] = (m_inc[g] - m_neg[g] - 1) & 64'hFFFF;
        end else begin
          m_k[g]++;
          if (m_amod[g] != 0 && m_amod[g] >= m_ainc[g])
            e_s[g] = ((m_k[g] * m_ainc[g]) / m_amod[g]) !=
                     (((m_k[g] - 1) * m_ainc[g]) / m_amod[g]);
        end
      end
      check(req, gen_strobe[g], e_s[g]);
    end
    @(negedge clk);
    check("R7", conv_strobe[0], conv_exp(cid0));
    check("R7", conv_strobe[1], conv_exp(cid1));
  endtask

  task automatic run_cfg(int g, logic sel, int inc, int modv, string req);
    logic [15:0] neg;
    neg = 16'(inc - modv - 1);
    wr(g, 0, {31'd0, sel});
    wr(g, 1, {neg, 16'(inc)});
    pulse(sel, !sel, "R5");
    for (int k = 1; k <= 2 * modv + 2; k++) begin
      pulse(sel, !sel, req);
      if (k % 3 == 0) pulse(!sel, sel, "R2");
      if (k % 5 == 0) pulse(1'b1, 1'b1, "R9");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int g = 0; g < 2; g++) begin
      m_src[g] = 0; m_inc[g] = 0; m_neg[g] = 0; m_ainc[g] = 0;
      m_amod[g] = 16'hFFFF; m_k[g] = 0; m_pend[g] = 0; e_s[g] = 0;
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", gen_strobe[0], 1'b0);
    check("R1", gen_strobe[1], 1'b0);
    check("R1", conv_strobe[0], 1'b0);
    for (int i = 0; i < 3; i++) begin
      pulse(1'b1, 1'b0, "R1");
      pulse(1'b0, 1'b1, "R1");
    end

    // common audio rates: modulus chosen from the base with the smaller remainder
    for (int g = 0; g < 2; g++) begin
      int rates [7] = '{8000, 11025, 16000, 22050, 32000, 44100, 48000};
      wr(1 - g, 1, {16'd3, 16'd4});   // other generator: modulus 0 (R6)
      for (int i = 0; i < 7; i++) begin
        logic s441;
        int mst;
        s441 = (44100 % rates[i]) < (48000 % rates[i]);
        mst = s441 ? 44100 : 48000;
        run_cfg(g, s441, 4, 4 * mst / rates[i], "R3");
      end
      // near-exhaustive grid, R4 when usable, R6 otherwise
      for (int inc = 1; inc <= 5; inc++)
        for (int md = 0; md <= 8; md++)
          run_cfg(g, logic'((inc + md) % 2), inc, md,
                  (md != 0 && md >= inc) ? "R4" : "R6");
    end

    // R5: pending settings follow the newly selected source
    wr(1, 1, {16'd3, 16'd4});
    run_cfg(0, 1'b0, 4, 4, "R4");
    wr(0, 0, 32'd1);
    wr(0, 1, {16'(1 - 3 - 1), 16'd1});
    pulse(1'b0, 1'b1, "R5");
    pulse(1'b1, 1'b0, "R5");
    for (int k = 0; k < 7; k++) pulse(1'b1, 1'b0, "R5");

    // R7: out-of-range IDs, then swapped IDs
    cid0 = 2'd0; cid1 = 2'd3;
    for (int k = 0; k < 6; k++) pulse(1'b1, 1'b0, "R7");
    cid0 = 2'd2; cid1 = 2'd1;

    // R8: both generators together, one rewritten mid-run
    wr(0, 0, 32'd0); wr(0, 1, {16'(4 - 6 - 1), 16'd4});
    wr(1, 0, 32'd0); wr(1, 1, {16'(3 - 7 - 1), 16'd3});
    for (int k = 0; k < 20; k++) pulse(1'b0, 1'b1, "R8");
    wr(0, 1, {16'(4 - 4 - 1), 16'd4});
    for (int k = 0; k < 20; k++) pulse(1'b0, 1'b1, "R8");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule